// File: doc/BRIEF.md
# Write Buffer with Read Bypass and Line-Fill Sequencer

This block sits between a copy-back, write-allocate cache and a word-wide memory port. When the cache misses, the block takes the missed word address and, if the replaced line is dirty, the victim line. Both are accepted in one cycle. The victim goes into a small buffer of whole-line write entries, and the miss read is sent to memory ahead of all the writes still waiting there. Each buffered entry is compared against the line of the pending read. If any entry holds that line, the read waits until that entry has been written to memory. Data is never forwarded out of the buffer.

The fill runs in one of two orders, chosen for each miss. In plain order, the words arrive from offset zero upward, and the processor is released once the whole line is in the cache. In critical-word-first order, the missed word is requested first and the rest of the line follows, wrapping past the end of the line. The processor is released as soon as the missed word arrives. Each returned word carries its offset in the line so the cache can write it. The buffer drains one line at a time, oldest first, whenever no read wants the memory port. A write-through, no-write-allocate cache never produces line writes, so in that configuration the victim inputs are ignored.

Top module: `wb_bypass_ctrl`

## Requirements
- R1: After reset no memory request, fill word or resume pulse is issued, the buffer-full flag is low, and no miss is accepted while none is offered.
- R2: A miss read accepted while a write entry is buffered issues its first memory request before any word of that entry is written.
- R3: A miss read whose line matches a buffered entry issues no memory request until the last word of that entry has been written; the fill data then equals the newly written data.
- R4: In copy-back mode a dirty victim line is captured in the same cycle as the miss is accepted and is later written to memory unchanged, with word k of the victim bus (bits k*DW +: DW) going to word offset k of the victim line.
- R5: In write-through mode (copy_back_i low) the victim dirty flag and victim data are ignored: no memory write follows and the buffer never fills.
- R6: The full flag is high when all buffer entries are valid; a copy-back miss with a dirty victim is not accepted while the buffer is full, and it is accepted once an entry has drained.
- R7: Entries drain in the order they were captured, each as consecutive write requests to offsets 0 up to the last word, one word per cycle, without interruption.
- R8: In plain order (wrap_mode_i low at acceptance) reads are requested at offsets 0 upward, and resume_o pulses for one cycle in the cycle after the last fill word.
- R9: In wrap order the first read is at the missed offset, the following ones go to increasing offsets modulo the line length, and resume_o pulses in the cycle after the first fill word.
- R10: Each fill word is tagged with the line offset it was read from, and the read addresses are {missed line, offset}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| copy_back_i | input | 1 | 1: copy-back write-allocate, 0: write-through no-write-allocate |
| wrap_mode_i | input | 1 | Fill order for the offered miss: 1 critical word first, 0 plain |
| miss_valid_i | input | 1 | A miss is offered |
| miss_addr_i | input | AW | Missed word address (line address, then offset bits) |
| miss_ready_o | output | 1 | Miss accepted in this cycle |
| victim_dirty_i | input | 1 | The replaced line is dirty |
| victim_line_i | input | AW-log2(LINE_WORDS) | Line address of the replaced line |
| victim_data_i | input | DW*LINE_WORDS | Victim words, word k at bits k*DW +: DW |
| fill_valid_o | output | 1 | A fill word is presented to the cache |
| fill_ofs_o | output | log2(LINE_WORDS) | Line offset of the fill word |
| fill_data_o | output | DW | Fill word data |
| resume_o | output | 1 | One-cycle pulse: the processor may continue |
| wbuf_full_o | output | 1 | All write-buffer entries are valid |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_rvalid_i | input | 1 | Read data returned (fixed latency) |
| mem_rdata_i | input | DW | Read data |

## Verification
Every missed offset of a line is tried in both fill orders. This separates the plain order from the wrap order, and it shows whether the wrap-around is computed modulo the line length and whether resume is tied to the first or the last word. A dirty-victim miss onto an empty buffer shows whether the read goes out ahead of the writes. A miss onto the line of the victim just captured tells a correct hazard hold from a stale read, because the fill data must then equal the victim data. Back-to-back dirty misses fill the buffer, which exposes the full stall, the drain order and the victim word placement. A final run in write-through mode with dirty flags raised shows whether any stray write escapes.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WAIT  = 2'd1,
    RD_ISSUE = 2'd2,
    RD_RECV  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/wbb_wbuf.sv
module wbb_wbuf #(
  parameter int LA_W       = 14,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int DEPTH      = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [LA_W-1:0]          push_line_i,
  input  logic [DW*LINE_WORDS-1:0] push_data_i,
  input  logic                     pop_i,
  input  logic [LA_W-1:0]          match_line_i,
  output logic                     match_o,
  output logic [LA_W-1:0]          head_line_o,
  output logic [DW*LINE_WORDS-1:0] head_data_o,
  output logic                     empty_o,
  output logic                     full_o
);
  localparam int LDW = DW * LINE_WORDS;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] vld_q;
  logic [LA_W-1:0]  line_q [DEPTH];
  logic [LDW-1:0]   data_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] hit;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  // compare the pending read line against every valid entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld_q[i] && (line_q[i] == match_line_i);
  end

  assign match_o     = |hit;
  assign head_line_o = line_q[head_q];
  assign head_data_o = data_q[head_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (push_i) begin
        vld_q[tail_q]  <= 1'b1;
        line_q[tail_q] <= push_line_i;
        data_q[tail_q] <= push_data_i;
        tail_q         <= ptr_next(tail_q);
      end
      if (pop_i) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= ptr_next(head_q);
      end
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wbb_fill_seq.sv
module wbb_fill_seq
  import wbb_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wrap_i,
  input  logic                         miss_valid_i,
  input  logic [AW-1:0]                miss_addr_i,
  input  logic                         stall_i,
  input  logic                         hazard_i,
  input  logic                         drain_act_i,
  input  logic                         rsp_valid_i,
  output logic                         accept_o,
  output logic [AW-$clog2(LINE_WORDS)-1:0] line_o,
  output logic                         claim_o,
  output logic                         rd_req_o,
  output logic [AW-1:0]                rd_addr_o,
  output logic                         fill_valid_o,
  output logic [$clog2(LINE_WORDS)-1:0] fill_ofs_o,
  output logic                         resume_o
);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam int LA_W  = AW - OFS_W;
  localparam logic [OFS_W-1:0] LAST = OFS_W'(LINE_WORDS - 1);

  rd_state_e        state_q, state_d;
  logic [LA_W-1:0]  line_q;
  logic [OFS_W-1:0] start_q, iss_cnt_q, rcv_cnt_q, iss_ofs;
  logic             wrap_q, resume_q;

  assign accept_o     = (state_q == RD_IDLE) && miss_valid_i && !stall_i;
  // memory port is reserved from acceptance until the last word returns
  assign claim_o      = accept_o || ((state_q == RD_WAIT) && !hazard_i) ||
                        (state_q == RD_ISSUE) || (state_q == RD_RECV);
  assign rd_req_o     = (state_q == RD_ISSUE);
  assign iss_ofs      = start_q + iss_cnt_q;
  assign rd_addr_o    = {line_q, iss_ofs};
  assign line_o       = line_q;
  assign fill_valid_o = rsp_valid_i && ((state_q == RD_ISSUE) || (state_q == RD_RECV));
  assign fill_ofs_o   = start_q + rcv_cnt_q;
  assign resume_o     = resume_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE:  if (accept_o) state_d = RD_WAIT;
      RD_WAIT:  if (!hazard_i && !drain_act_i) state_d = RD_ISSUE;
      RD_ISSUE: if (iss_cnt_q == LAST) state_d = RD_RECV;
      RD_RECV:  state_d = RD_RECV;
      default:  state_d = RD_IDLE;
    endcase
    if (fill_valid_o && (rcv_cnt_q == LAST)) state_d = RD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_IDLE;
      line_q    <= '0;
      start_q   <= '0;
      iss_cnt_q <= '0;
      rcv_cnt_q <= '0;
      wrap_q    <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= fill_valid_o && (wrap_q ? (rcv_cnt_q == '0) : (rcv_cnt_q == LAST));
      if (accept_o) begin
        line_q    <= miss_addr_i[AW-1:OFS_W];
        start_q   <= wrap_i ? miss_addr_i[OFS_W-1:0] : '0;
        wrap_q    <= wrap_i;
        iss_cnt_q <= '0;
        rcv_cnt_q <= '0;
      end
      if (rd_req_o)     iss_cnt_q <= iss_cnt_q + OFS_W'(1);
      if (fill_valid_o) rcv_cnt_q <= rcv_cnt_q + OFS_W'(1);
    end
  end

  // R3
  hazard_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !hazard_i);

  // R2
  issue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !drain_act_i);

  // R8
  resume_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
endmodule

// File: rtl/wbb_mem_arb.sv
module wbb_mem_arb #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               claim_i,
  input  logic                               empty_i,
  input  logic [AW-$clog2(LINE_WORDS)-1:0]   head_line_i,
  input  logic [DW*LINE_WORDS-1:0]           head_data_i,
  input  logic                               rd_req_i,
  input  logic [AW-1:0]                      rd_addr_i,
  output logic                               drain_act_o,
  output logic                               pop_o,
  output logic                               mem_req_o,
  output logic                               mem_we_o,
  output logic [AW-1:0]                      mem_addr_o,
  output logic [DW-1:0]                      mem_wdata_o
);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(LINE_WORDS - 1);

  logic             act_q;
  logic [OFS_W-1:0] wcnt_q;
  logic             start;

  assign start       = !act_q && !empty_i && !claim_i;
  assign pop_o       = act_q && (wcnt_q == LAST);
  assign drain_act_o = act_q;

  always_comb begin
    if (act_q) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = {head_line_i, wcnt_q};
      mem_wdata_o = head_data_i[wcnt_q*DW +: DW];
    end else begin
      mem_req_o   = rd_req_i;
      mem_we_o    = 1'b0;
      mem_addr_o  = rd_addr_i;
      mem_wdata_o = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wcnt_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      wcnt_q <= '0;
    end else if (act_q) begin
      wcnt_q <= wcnt_q + OFS_W'(1);
      if (wcnt_q == LAST) act_q <= 1'b0;
    end
  end

  // R7
  drain_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !pop_o) |=> (act_q && mem_we_o));

  // R2
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> !rd_req_i);
endmodule

// File: rtl/wb_bypass_ctrl.sv
module wb_bypass_ctrl #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int DEPTH      = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                copy_back_i,
  input  logic                                wrap_mode_i,
  input  logic                                miss_valid_i,
  input  logic [AW-1:0]                       miss_addr_i,
  output logic                                miss_ready_o,
  input  logic                                victim_dirty_i,
  input  logic [AW-$clog2(LINE_WORDS)-1:0]    victim_line_i,
  input  logic [DW*LINE_WORDS-1:0]            victim_data_i,
  output logic                                fill_valid_o,
  output logic [$clog2(LINE_WORDS)-1:0]       fill_ofs_o,
  output logic [DW-1:0]                       fill_data_o,
  output logic                                resume_o,
  output logic                                wbuf_full_o,
  output logic                                mem_req_o,
  output logic                                mem_we_o,
  output logic [AW-1:0]                       mem_addr_o,
  output logic [DW-1:0]                       mem_wdata_o,
  input  logic                                mem_rvalid_i,
  input  logic [DW-1:0]                       mem_rdata_i
);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam int LA_W  = AW - OFS_W;
  localparam int LDW   = DW * LINE_WORDS;

  logic            need_slot, stall, accept, push, pop, hazard;
  logic            full, empty, claim, drain_act, rd_req;
  logic [LA_W-1:0] rd_line, head_line;
  logic [LDW-1:0]  head_data;
  logic [AW-1:0]   rd_addr;

  // write-through caches produce no line writes
  assign need_slot    = copy_back_i && victim_dirty_i;
  assign stall        = need_slot && full;
  assign push         = accept && need_slot;
  assign miss_ready_o = accept;
  assign wbuf_full_o  = full;
  assign fill_data_o  = mem_rdata_i;

  wbb_wbuf #(
    .LA_W(LA_W), .DW(DW), .LINE_WORDS(LINE_WORDS), .DEPTH(DEPTH)
  ) u_wbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_line_i  (victim_line_i),
    .push_data_i  (victim_data_i),
    .pop_i        (pop),
    .match_line_i (rd_line),
    .match_o      (hazard),
    .head_line_o  (head_line),
    .head_data_o  (head_data),
    .empty_o      (empty),
    .full_o       (full)
  );

  wbb_fill_seq #(
    .AW(AW), .LINE_WORDS(LINE_WORDS)
  ) u_fill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wrap_i       (wrap_mode_i),
    .miss_valid_i (miss_valid_i),
    .miss_addr_i  (miss_addr_i),
    .stall_i      (stall),
    .hazard_i     (hazard),
    .drain_act_i  (drain_act),
    .rsp_valid_i  (mem_rvalid_i),
    .accept_o     (accept),
    .line_o       (rd_line),
    .claim_o      (claim),
    .rd_req_o     (rd_req),
    .rd_addr_o    (rd_addr),
    .fill_valid_o (fill_valid_o),
    .fill_ofs_o   (fill_ofs_o),
    .resume_o     (resume_o)
  );

  wbb_mem_arb #(
    .AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)
  ) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .claim_i     (claim),
    .empty_i     (empty),
    .head_line_i (head_line),
    .head_data_i (head_data),
    .rd_req_i    (rd_req),
    .rd_addr_i   (rd_addr),
    .drain_act_o (drain_act),
    .pop_o       (pop),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  // R5
  wt_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_back_i |-> !push);
endmodule

// File: tb/tb_wb_bypass_ctrl.sv
`timescale 1ns/1ps
module tb_wb_bypass_ctrl;
  localparam int AW = 8, DW = 16, LW = 4, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cb = 1'b1, wrap = 1'b0, mv = 1'b0, vd = 1'b0;
  logic [AW-1:0] maddr = '0;
  logic [5:0] vline = '0;
  logic [DW*LW-1:0] vdata = '0;
  logic mready, fvalid, resume, full, mreq, mwe;
  logic [1:0] fofs;
  logic [DW-1:0] fdata, mwdata;
  logic [AW-1:0] maddr_o;
  logic v1, v2;
  logic [DW-1:0] d1, d2;

  always #2.5 clk = ~clk;

  wb_bypass_ctrl #(.AW(AW), .DW(DW), .LINE_WORDS(LW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .copy_back_i(cb), .wrap_mode_i(wrap),
    .miss_valid_i(mv), .miss_addr_i(maddr), .miss_ready_o(mready),
    .victim_dirty_i(vd), .victim_line_i(vline), .victim_data_i(vdata),
    .fill_valid_o(fvalid), .fill_ofs_o(fofs), .fill_data_o(fdata),
    .resume_o(resume), .wbuf_full_o(full), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr_o), .mem_wdata_o(mwdata), .mem_rvalid_i(v2), .mem_rdata_i(d2));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  logic [1:0]    exp_f_ofs [256];
  logic [DW-1:0] exp_f_dat [256];
  logic          exp_trig [256];
  logic [AW-1:0] exp_r_addr [256];
  logic [AW-1:0] exp_w_addr [256];
  logic [DW-1:0] exp_w_dat [256];
  int r_req_at [256];
  int w_req_at [256];
  int nf_exp = 0, nw_exp = 0, fill_n = 0, rreq_n = 0, wreq_n = 0, req_n = 0;
  logic prev_trig = 1'b0;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = DW'(a * 7 + 3);
      exp_mem[a] = DW'(a * 7 + 3);
    end
  end

  // memory model: two-cycle read latency
  always @(posedge clk) begin
    v1 <= mreq && !mwe;
    d1 <= mem[maddr_o];
    v2 <= v1;
    d2 <= d1;
    if (mreq && mwe) mem[maddr_o] <= mwdata;
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (prev_trig) chk(resume == 1'b1, "R8/R9 resume after trigger word", int'(resume), 1);
    else if (resume) chk(1'b0, "R8/R9 stray resume", 1, 0);
    prev_trig = fvalid && exp_trig[fill_n];
    if (mreq) begin
      req_n++;
      if (mwe) begin
        if (wreq_n >= nw_exp) chk(1'b0, "R5 unexpected write", int'(maddr_o), -1);
        else begin
          chk(maddr_o == exp_w_addr[wreq_n], "R7 write address", int'(maddr_o), int'(exp_w_addr[wreq_n]));
          chk(mwdata == exp_w_dat[wreq_n], "R4 write data", int'(mwdata), int'(exp_w_dat[wreq_n]));
        end
        w_req_at[wreq_n] = req_n;
        wreq_n++;
      end else begin
        chk(maddr_o == exp_r_addr[rreq_n], "R10 R9 read address", int'(maddr_o), int'(exp_r_addr[rreq_n]));
        r_req_at[rreq_n] = req_n;
        rreq_n++;
      end
    end
    if (fvalid) begin
      chk(fofs == exp_f_ofs[fill_n], "R10 fill offset", int'(fofs), int'(exp_f_ofs[fill_n]));
      chk(fdata == exp_f_dat[fill_n], "R10/R3 fill data", int'(fdata), int'(exp_f_dat[fill_n]));
      fill_n++;
    end
  end

  task automatic drive_miss(input logic [AW-1:0] a, input logic dirty, input logic [5:0] vl, input logic wr);
    logic [1:0] st;
    st = wr ? a[1:0] : 2'd0;
    for (int k = 0; k < LW; k++) begin
      logic [1:0] o;
      o = st + 2'(k);
      exp_f_ofs[nf_exp + k]  = o;
      exp_r_addr[nf_exp + k] = {a[7:2], o};
      exp_f_dat[nf_exp + k]  = exp_mem[{a[7:2], o}];
      exp_trig[nf_exp + k]   = wr ? (k == 0) : (k == LW - 1);
    end
    nf_exp += LW;
    for (int k = 0; k < LW; k++) begin
      logic [DW-1:0] w;
      w = DW'((nw_exp + k) * 29 + 16'h4000 + int'(vl));
      vdata[k*DW +: DW] = w;
      if (dirty && cb) begin
        exp_w_addr[nw_exp + k] = {vl, 2'(k)};
        exp_w_dat[nw_exp + k]  = w;
        exp_mem[{vl, 2'(k)}]   = w;
      end
    end
    if (dirty && cb) nw_exp += LW;
    maddr = a; vd = dirty; vline = vl; wrap = wr; mv = 1'b1;
  endtask

  task automatic wait_accept();
    while (!mready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    mv = 1'b0; vd = 1'b0;
  endtask

  task automatic submit(input logic [AW-1:0] a, input logic dirty, input logic [5:0] vl, input logic wr);
    drive_miss(a, dirty, vl, wr);
    #0.1;
    wait_accept();
  endtask

  task automatic wait_fills(input int n);
    while (fill_n < n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_writes(input int n);
    while (wreq_n < n) begin @(negedge clk); #1; end
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", fill_n, nf_exp);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ri, wi;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(mreq == 1'b0, "R1 mem_req in reset", int'(mreq), 0);
    chk(fvalid == 1'b0, "R1 fill_valid in reset", int'(fvalid), 0);
    chk(resume == 1'b0, "R1 resume in reset", int'(resume), 0);
    chk(full == 1'b0, "R1 full in reset", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mready == 1'b0, "R1 no accept without miss", int'(mready), 0);
    chk(mreq == 1'b0, "R1 idle memory after reset", int'(mreq), 0);

    // R8 R9: every offset in both orders
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < LW; o++) begin
        submit({6'(m * 4 + o + 1), 2'(o)}, 1'b0, 6'd0, m[0]);
        wait_fills(nf_exp);
        repeat (2) @(negedge clk);
        #1;
      end
    end

    // R2: read bypasses the victim captured with it
    ri = nf_exp; wi = nw_exp;
    submit({6'd20, 2'd2}, 1'b1, 6'd40, 1'b1);
    wait_fills(nf_exp);
    wait_writes(nw_exp);
    chk(r_req_at[ri] < w_req_at[wi], "R2 read ahead of buffered write", r_req_at[ri], w_req_at[wi]);

    // R3: read of a line still in the buffer waits for its drain
    wi = nw_exp;
    submit({6'd21, 2'd0}, 1'b1, 6'd41, 1'b0);
    ri = nf_exp;
    submit({6'd41, 2'd1}, 1'b0, 6'd0, 1'b0);
    wait_fills(nf_exp);
    wait_writes(nw_exp);
    chk(w_req_at[wi + LW - 1] < r_req_at[ri], "R3 hazard read after drain", r_req_at[ri], w_req_at[wi + LW - 1]);

    // R6 R7: fill the buffer with back-to-back dirty misses
    for (int i = 0; i < DEPTH; i++) submit({6'(30 + i), 2'd0}, 1'b1, 6'(50 + i), 1'b0);
    chk(full == 1'b1, "R6 full after four victims", int'(full), 1);
    wait_fills(nf_exp);
    drive_miss({6'd34, 2'd3}, 1'b1, 6'd54, 1'b1);
    @(negedge clk); #1;
    chk(mready == 1'b0, "R6 dirty miss stalls while full", int'(mready), 0);
    chk(full == 1'b1, "R6 full held while stalled", int'(full), 1);
    wait_accept();
    wait_fills(nf_exp);
    wait_writes(nw_exp);
    chk(full == 1'b0, "R6 full cleared after drain", int'(full), 0);
    // R4: read the victim lines back
    for (int i = 0; i <= DEPTH; i++) begin
      submit({6'(50 + i), 2'(i)}, 1'b0, 6'd0, 1'b1);
      wait_fills(nf_exp);
    end

    // R5: write-through ignores dirty victims
    cb = 1'b0;
    for (int i = 0; i < 6; i++) begin
      submit({6'(10 + i), 2'(i)}, 1'b1, 6'(60 + i), i[0]);
      wait_fills(nf_exp);
    end
    repeat (20) @(negedge clk);
    #1;
    chk(wreq_n == nw_exp, "R5 no writes in write-through", wreq_n, nw_exp);
    chk(full == 1'b0, "R5 buffer never fills", int'(full), 0);
    submit({6'd60, 2'd0}, 1'b0, 6'd0, 1'b0);
    wait_fills(nf_exp);
    repeat (4) @(negedge clk);
    chk(fill_n == nf_exp, "R10 total fill words", fill_n, nf_exp);
    chk(rreq_n == nf_exp, "R10 total read requests", rreq_n, nf_exp);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule